// File: doc/BRIEF.md
# Bit-Plane Frame Write Address Generator

This block produces the frame-buffer write address for a stream of bit-plane words bound for a large LED panel that is driven at 1/8 duty in horizontal zones. Each incoming word holds one bit weight of a group of pixels. The block steps through the words of one frame with four chained counters: bit weight, column word, row inside a zone, and zone. The bit-weight counter runs fastest, but it drives the most significant address bits. Every bit weight therefore collects in its own contiguous segment of memory. The display readout can then fetch one whole weight plane at a time.

A frame-start pulse clears the counters and arms the generator. Each cycle with the word-valid strobe high consumes one address. After the last word of the frame has been consumed, a one-cycle done pulse is raised. The counters then rest at zero until the next frame start. The default sizing is eight weights, 100 column words of eight pixels, eight rows per zone and 32 zones. That is an 800×256 panel with an 18-bit address.

Top module: `bpw_write_addr_gen`

## Requirements
- R1: The address is the concatenation {weight, zone, row, column}, from most to least significant. With the default sizing, the weight is in bits [17:15], the zone in [14:10], the row in [9:7] and the column in [6:0].
- R2: On every accepted word (word_valid high while armed, with no frame_start) the weight field advances by one. On the word where the weight is 7 (NUM_WEIGHTS-1), the weight returns to 0 and the column advances.
- R3: When the column carry arrives while the column is NUM_COLS-1 (99 by default), the column returns to 0 and the row advances.
- R4: When the row carry arrives while the row is NUM_ROWS-1 (7), the row returns to 0 and the zone advances.
- R5: The word consumed at the final address (all fields at their maximum) ends the frame. In the next cycle, frame_done is 1 for exactly one cycle and the address is 0.
- R6: After a frame has ended, word_valid has no effect. The address stays 0 and frame_done stays 0 until frame_start.
- R7: In a cycle with word_valid low, the address does not change.
- R8: frame_start clears the address to 0 in the next cycle and arms the generator. When word_valid is high in the same cycle, the word is not counted.
- R9: A synchronous active-high reset sets the address to 0 and frame_done to 0, and leaves the generator armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | One bit-plane word is presented this cycle |
| frame_start | input | 1 | Clears the counters and arms a new frame |
| wr_addr | output | ADDR_W (18) | Write address for the current word |
| frame_done | output | 1 | One-cycle pulse after the last word of a frame |

## Verification
The hardest conditions to reach from the ports are the late carries: the zone wrap that ends a frame, and the row carry at the full 800-column geometry. These sit thousands of words into a frame. Two instances therefore take the same stimulus. A reduced instance (five columns, four zones) is swept through complete frames, including its idle state after the end of a frame. A default-sized instance runs past its first zone carry at word 6400. Frame restarts, gaps in the strobe and a mid-run reset are placed between the long sweeps.

// File: rtl/bpw_pkg.sv
package bpw_pkg;
  // Width needed to hold values 0 .. n-1 (at least one bit).
  function automatic int unsigned field_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/bpw_digit.sv
module bpw_digit #(
  parameter int unsigned MODULUS = 8,
  parameter int unsigned W       = bpw_pkg::field_w(MODULUS)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  output logic [W-1:0] count,
  output logic         carry
);
  localparam logic [W-1:0] LAST = W'(MODULUS - 1);

  assign carry = step && (count == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)
      count <= '0;
    else if (step)
      count <= carry ? '0 : count + 1'b1;
  end

  // R2 R3 R4: a digit never leaves its range
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    count <= LAST);
  // R2 R3 R4: a digit at its last value that is stepped returns to zero
  assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (step && !clr && count == LAST) |=> (count == '0));
endmodule

// File: rtl/bpw_frame_ctrl.sv
module bpw_frame_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  input  logic frame_end,
  output logic armed,
  output logic frame_done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      armed      <= 1'b1;
      frame_done <= 1'b0;
    end else begin
      if (frame_start)
        armed <= 1'b1;
      else if (frame_end)
        armed <= 1'b0;
      frame_done <= frame_end && !frame_start;
    end
  end

  // R5: done is a single-cycle pulse
  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);
  // R6: once a frame ends, the generator stays idle until the next frame start
  assert_idle_after_end_R6: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !frame_start) |-> !armed);
endmodule

// File: rtl/bpw_write_addr_gen.sv
module bpw_write_addr_gen #(
  parameter int unsigned NUM_WEIGHTS = 8,
  parameter int unsigned NUM_COLS    = 100,
  parameter int unsigned NUM_ROWS    = 8,
  parameter int unsigned NUM_ZONES   = 32,
  parameter int unsigned WGT_W  = bpw_pkg::field_w(NUM_WEIGHTS),
  parameter int unsigned COL_W  = bpw_pkg::field_w(NUM_COLS),
  parameter int unsigned ROW_W  = bpw_pkg::field_w(NUM_ROWS),
  parameter int unsigned ZONE_W = bpw_pkg::field_w(NUM_ZONES),
  parameter int unsigned ADDR_W = WGT_W + ZONE_W + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_valid,
  input  logic              frame_start,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              frame_done
);
  logic [WGT_W-1:0]  wgt_q;
  logic [COL_W-1:0]  col_q;
  logic [ROW_W-1:0]  row_q;
  logic [ZONE_W-1:0] zone_q;
  logic wgt_c, col_c, row_c, zone_c;
  logic armed, accept;

  assign accept = word_valid && armed && !frame_start;

  // Fastest digit: bit weight
  bpw_digit #(.MODULUS(NUM_WEIGHTS), .W(WGT_W)) u_wgt (
    .clk(clk), .rst(rst), .clr(frame_start), .step(accept),
    .count(wgt_q), .carry(wgt_c));

  bpw_digit #(.MODULUS(NUM_COLS), .W(COL_W)) u_col (
    .clk(clk), .rst(rst), .clr(frame_start), .step(wgt_c),
    .count(col_q), .carry(col_c));

  bpw_digit #(.MODULUS(NUM_ROWS), .W(ROW_W)) u_row (
    .clk(clk), .rst(rst), .clr(frame_start), .step(col_c),
    .count(row_q), .carry(row_c));

  // Slowest digit: zone; its carry closes the frame
  bpw_digit #(.MODULUS(NUM_ZONES), .W(ZONE_W)) u_zone (
    .clk(clk), .rst(rst), .clr(frame_start), .step(row_c),
    .count(zone_q), .carry(zone_c));

  bpw_frame_ctrl u_ctrl (
    .clk(clk), .rst(rst), .frame_start(frame_start), .frame_end(zone_c),
    .armed(armed), .frame_done(frame_done));

  // Weight on top so each bit weight owns one memory segment
  assign wr_addr = {wgt_q, zone_q, row_q, col_q};

  // R7: no strobe and no restart keeps the address
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!word_valid && !frame_start) |=> $stable(wr_addr));
  // R8: a frame start leaves a zero address and no done pulse
  assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (wr_addr == '0 && !frame_done));
  // R5: the done pulse coincides with a zero address
  assert_done_addr_R5: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (wr_addr == '0));
  // R2: an accepted word changes the address
  assert_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (word_valid && !frame_start && !frame_done && $past(!frame_done)
     && wr_addr != '0) |=> !$stable(wr_addr));
endmodule

// File: tb/bpw_write_addr_gen_tb.sv
module bpw_write_addr_gen_tb;
  localparam int CLK_P = 10;
  localparam int S_TOTAL = 8 * 5 * 8 * 4;
  localparam int B_TOTAL = 8 * 100 * 8 * 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wv  = 1'b0;
  logic fs  = 1'b0;
  logic [10:0] addr_s;
  logic [17:0] addr_b;
  logic done_s, done_b;

  int vecs = 0;
  int errs = 0;
  int ns = 0, nb = 0;
  bit act_s = 1'b1, act_b = 1'b1, dx_s = 1'b0, dx_b = 1'b0;
  bit finished = 1'b0;
  string tag = "R9";

  always #(CLK_P/2) clk = ~clk;

  bpw_write_addr_gen #(.NUM_WEIGHTS(8), .NUM_COLS(5), .NUM_ROWS(8), .NUM_ZONES(4)) u_dut (
    .clk(clk), .rst(rst), .word_valid(wv), .frame_start(fs),
    .wr_addr(addr_s), .frame_done(done_s));

  bpw_write_addr_gen u_dut_full (
    .clk(clk), .rst(rst), .word_valid(wv), .frame_start(fs),
    .wr_addr(addr_b), .frame_done(done_b));

  function automatic logic [10:0] exp_s(input int n);
    int f, c, r, z;
    f = n % 8; c = (n / 8) % 5; r = (n / 40) % 8; z = (n / 320) % 4;
    return {3'(f), 2'(z), 3'(r), 3'(c)};
  endfunction

  function automatic logic [17:0] exp_b(input int n);
    int f, c, r, z;
    f = n % 8; c = (n / 8) % 100; r = (n / 800) % 8; z = (n / 6400) % 32;
    return {3'(f), 5'(z), 3'(r), 7'(c)};
  endfunction

  task automatic check_all();
    vecs++;
    if (addr_s !== exp_s(ns)) begin
      errs++; $display("FAIL %s small addr actual %h expected %h", tag, addr_s, exp_s(ns));
    end
    vecs++;
    if (done_s !== dx_s) begin
      errs++; $display("FAIL %s small done actual %b expected %b", tag, done_s, dx_s);
    end
    vecs++;
    if (addr_b !== exp_b(nb)) begin
      errs++; $display("FAIL %s full addr actual %h expected %h", tag, addr_b, exp_b(nb));
    end
    vecs++;
    if (done_b !== dx_b) begin
      errs++; $display("FAIL %s full done actual %b expected %b", tag, done_b, dx_b);
    end
  endtask

  task automatic model(input bit v, input bit s, input int total,
                       inout int n, inout bit act, inout bit dx);
    dx = 1'b0;
    if (s) begin
      n = 0; act = 1'b1;
    end else if (v && act) begin
      n++;
      if (n == total) begin
        n = 0; act = 1'b0; dx = 1'b1;
      end
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, check at the next falling edge.
  task automatic step(input bit v, input bit s);
    wv = v; fs = s;
    @(posedge clk);
    model(v, s, S_TOTAL, ns, act_s, dx_s);
    model(v, s, B_TOTAL, nb, act_b, dx_b);
    @(negedge clk);
    check_all();
  endtask

  task automatic do_reset();
    rst = 1'b1; wv = 1'b0; fs = 1'b0;
    @(posedge clk);
    ns = 0; nb = 0; act_s = 1'b1; act_b = 1'b1; dx_s = 1'b0; dx_b = 1'b0;
    @(negedge clk);
    tag = "R9";
    check_all();
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errs++;
    $display("FAIL watchdog: run did not complete, actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: the first weights of the first word group land in the top field
    tag = "R1";
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0);
    // R2: weight carry into column
    tag = "R2";
    for (int i = 0; i < 24; i++) step(1'b1, 1'b0);
    // R7: gaps in the strobe
    tag = "R7";
    for (int i = 0; i < 30; i++) step((i % 3) == 0, 1'b0);
    // R3: column wraps (small at 40 words, full at 800)
    tag = "R3";
    while (nb < 900) step(1'b1, 1'b0);
    // R4 then R5: complete the small frame
    while (act_s) begin
      tag = (ns == S_TOTAL - 1) ? "R5" : "R4";
      step(1'b1, 1'b0);
    end
    tag = "R5";
    step(1'b0, 1'b0);
    // R6: valid words after the frame ended are ignored by the small instance
    tag = "R6";
    for (int i = 0; i < 30; i++) step(1'b1, 1'b0);
    // R8: restart with a simultaneous strobe, then a mid-frame restart
    tag = "R8";
    step(1'b1, 1'b1);
    for (int i = 0; i < 50; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    // R4: full instance carries row into zone at word 6400
    tag = "R4";
    for (int i = 0; i < 6500; i++) step(1'b1, 1'b0);
    // R9: reset in the middle of a frame
    @(negedge clk);
    do_reset();
    tag = "R9";
    step(1'b0, 1'b0);
    finish_run();
  end
endmodule